// File: doc/BRIEF.md
# I2C Register Port with Auto-Increment

This block is a serial-bus slave that gives a host access to a small bank of eight-bit configuration registers. The bank holds a read-only view of external pin levels and five writable settings: two rate values, two duty values and an output-select byte. The block works entirely in a fast system clock domain. It samples the bus clock and data lines through a synchronizer chain, detects bus conditions and bit edges from the sampled levels, and drives a single pull-down enable for the data line.

A write transfer carries the slave address, then a command byte, then data. The command byte holds a three-bit register index and a step flag. When the step flag is set, the index advances after every data byte, in both directions, and wraps to zero after the last register. A read transfer returns bytes starting at the stored index until the host declines with a not-acknowledge. The stored index survives a repeated start and the end of a transfer, so a host can select a register with a short write and then read it back.

Top module: `i2c_regport`

## Requirements
- R1: The slave responds only to the 7-bit address 1100010 when parameter ADDR_SEL is 0, or 1100011 when it is 1. On any other address it leaves SDA released, including during the acknowledge slot, and it ignores all later bytes until the next START or STOP.
- R2: The eighth bit of the address byte selects the direction: 1 means the slave transmits data and 0 means the host writes.
- R3: The first byte written after an acknowledged address is the command byte. Bit 4 is the step flag and bits 2:0 are the register index. The index and flag reset to zero, so a read issued right after reset returns register 0.
- R4: Index map: 0 returns the pin levels zero-extended to 8 bits; 1 = rate A (reset 00h); 2 = duty A (reset 80h); 3 = rate B (reset 00h); 4 = duty B (reset 80h); 5 = output select (reset 00h). Indices 6 and 7 read as 00h and ignore writes. The five writable registers are visible on output ports.
- R5: With the step flag set, the index increments after each data byte that is written or read, and it goes from 5 (or above) back to 0. With the flag clear, the index does not change.
- R6: A data byte written to index 0 is acknowledged and changes no register.
- R7: SDA falling while SCL is high is a START; SDA rising while SCL is high is a STOP. Either condition releases SDA. A START restarts address decoding from any state.
- R8: The slave changes its SDA drive only while the sampled SCL is low, and it shifts data out MSB first.
- R9: During a read, the slave keeps sending bytes as long as the host acknowledges and stops after a not-acknowledge. A repeated START leaves the register index unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | Pull-down enable for the data line (1 = drive low) |
| pins_i | input | PIN_W (4) | External pin levels read through index 0 |
| rate_a_o | output | 8 | Register at index 1 |
| duty_a_o | output | 8 | Register at index 2 |
| rate_b_o | output | 8 | Register at index 3 |
| duty_b_o | output | 8 | Register at index 4 |
| led_sel_o | output | 8 | Register at index 5 |

## Verification
A vector table first writes one byte to each index, including index 0 and an unused index, and then reads it back through a repeated start. This separates writable, read-only and unmapped slots and confirms the index map. Stepped bursts begin at indices 4 and 5 so that both a write and a read cross the wrap point. A read without the step flag checks that the index holds, and a bare read after an earlier command shows that the index persists between transfers. A transfer to the other variant's address checks that the slave stays silent, and a following START checks that it recovers.

// File: rtl/i2c_regport_pkg.sv
package i2c_regport_pkg;

   localparam int DATA_W   = 8;
   localparam int PTR_W    = 3;
   localparam int NUM_REGS = 6;

   localparam logic [PTR_W-1:0] IDX_PINS   = 3'd0;
   localparam logic [PTR_W-1:0] IDX_LAST   = 3'(NUM_REGS - 1);

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_ADDR,
      ST_ADDR_ACK,
      ST_CMD,
      ST_CMD_ACK,
      ST_WDATA,
      ST_WDATA_ACK,
      ST_RDATA,
      ST_RACK,
      ST_IGNORE
   } bus_state_e;

   function automatic logic [DATA_W-1:0] reg_default(input int idx);
      return (idx == 2 || idx == 4) ? 8'h80 : 8'h00;
   endfunction

   function automatic logic [PTR_W-1:0] step_index(input logic [PTR_W-1:0] p);
      return (p >= IDX_LAST) ? '0 : p + 1'b1;
   endfunction

endpackage

// File: rtl/i2c_line_sampler.sv
module i2c_line_sampler #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_lvl,
   output logic sda_lvl,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);

   if (STAGES < 2) begin : g_bad_stages
      $error("i2c_line_sampler: STAGES must be at least 2");
   end

   logic [STAGES-1:0] scl_sh, sda_sh;
   logic              scl_prev, sda_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_sh   <= '1;
         sda_sh   <= '1;
         scl_prev <= 1'b1;
         sda_prev <= 1'b1;
      end else begin
         scl_sh   <= {scl_sh[STAGES-2:0], scl_i};
         sda_sh   <= {sda_sh[STAGES-2:0], sda_i};
         scl_prev <= scl_sh[STAGES-1];
         sda_prev <= sda_sh[STAGES-1];
      end
   end

   assign scl_lvl   = scl_sh[STAGES-1];
   assign sda_lvl   = sda_sh[STAGES-1];
   assign scl_rise  = scl_lvl & ~scl_prev;
   assign scl_fall  = ~scl_lvl & scl_prev;
   assign start_det = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
   assign stop_det  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;

endmodule

// File: rtl/regport_bank.sv
module regport_bank
   import i2c_regport_pkg::*;
#(
   parameter int PIN_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [PTR_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [PTR_W-1:0]  rd_idx,
   input  logic [PIN_W-1:0]  pins_i,
   output logic [DATA_W-1:0] rd_data,
   output logic [DATA_W-1:0] rate_a_o,
   output logic [DATA_W-1:0] duty_a_o,
   output logic [DATA_W-1:0] rate_b_o,
   output logic [DATA_W-1:0] duty_b_o,
   output logic [DATA_W-1:0] led_sel_o
);

   logic [DATA_W-1:0] store [1:NUM_REGS-1];

   for (genvar i = 1; i < NUM_REGS; i++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            store[i] <= reg_default(i);
         else if (wr_en && wr_idx == PTR_W'(i))
            store[i] <= wr_data;
      end
   end

   always_comb begin
      rd_data = '0;
      if (rd_idx == IDX_PINS)
         rd_data = DATA_W'(pins_i);
      for (int i = 1; i < NUM_REGS; i++)
         if (rd_idx == PTR_W'(i))
            rd_data = store[i];
   end

   assign rate_a_o  = store[1];
   assign duty_a_o  = store[2];
   assign rate_b_o  = store[3];
   assign duty_b_o  = store[4];
   assign led_sel_o = store[5];

endmodule

// File: rtl/i2c_slave_engine.sv
module i2c_slave_engine
   import i2c_regport_pkg::*;
#(
   parameter logic [6:0] SLAVE_ADDR = 7'b1100010
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              sda_lvl,
   input  logic              start_det,
   input  logic              stop_det,
   input  logic [DATA_W-1:0] rd_data,
   output logic              sda_oe,
   output logic [PTR_W-1:0]  idx,
   output logic              step_en,
   output logic              cmd_load,
   output logic              wr_en,
   output logic [PTR_W-1:0]  wr_idx,
   output logic [DATA_W-1:0] wr_data
);

   bus_state_e        state;
   logic [3:0]        bit_cnt;
   logic [DATA_W-1:0] rx_sh;
   logic [DATA_W-1:0] tx_byte;
   logic              rd_dir;
   logic              host_nack;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         bit_cnt   <= '0;
         rx_sh     <= '0;
         tx_byte   <= '0;
         rd_dir    <= 1'b0;
         host_nack <= 1'b0;
         sda_oe    <= 1'b0;
         idx       <= '0;
         step_en   <= 1'b0;
         cmd_load  <= 1'b0;
         wr_en     <= 1'b0;
         wr_idx    <= '0;
         wr_data   <= '0;
      end else begin
         wr_en    <= 1'b0;
         cmd_load <= 1'b0;
         if (start_det) begin
            state   <= ST_ADDR;
            bit_cnt <= '0;
            sda_oe  <= 1'b0;
         end else if (stop_det) begin
            state  <= ST_IDLE;
            sda_oe <= 1'b0;
         end else begin
            unique case (state)
               ST_ADDR, ST_CMD, ST_WDATA: begin
                  if (scl_rise && bit_cnt < 4'd8) begin
                     rx_sh   <= {rx_sh[DATA_W-2:0], sda_lvl};
                     bit_cnt <= bit_cnt + 4'd1;
                  end else if (scl_fall && bit_cnt == 4'd8) begin
                     if (state == ST_ADDR) begin
                        if (rx_sh[7:1] == SLAVE_ADDR) begin
                           rd_dir <= rx_sh[0];
                           sda_oe <= 1'b1;
                           state  <= ST_ADDR_ACK;
                        end else begin
                           state <= ST_IGNORE;
                        end
                     end else if (state == ST_CMD) begin
                        step_en  <= rx_sh[4];
                        idx      <= rx_sh[PTR_W-1:0];
                        cmd_load <= 1'b1;
                        sda_oe   <= 1'b1;
                        state    <= ST_CMD_ACK;
                     end else begin
                        wr_en   <= 1'b1;
                        wr_idx  <= idx;
                        wr_data <= rx_sh;
                        if (step_en) idx <= step_index(idx);
                        sda_oe  <= 1'b1;
                        state   <= ST_WDATA_ACK;
                     end
                  end
               end
               ST_ADDR_ACK, ST_CMD_ACK, ST_WDATA_ACK: begin
                  if (scl_fall) begin
                     bit_cnt <= '0;
                     if (state == ST_ADDR_ACK && rd_dir) begin
                        tx_byte <= rd_data;
                        sda_oe  <= ~rd_data[DATA_W-1];
                        state   <= ST_RDATA;
                     end else begin
                        sda_oe <= 1'b0;
                        state  <= (state == ST_ADDR_ACK) ? ST_CMD : ST_WDATA;
                     end
                  end
               end
               ST_RDATA: begin
                  if (scl_rise) begin
                     bit_cnt <= bit_cnt + 4'd1;
                  end else if (scl_fall) begin
                     if (bit_cnt == 4'd8) begin
                        sda_oe <= 1'b0;
                        if (step_en) idx <= step_index(idx);
                        state  <= ST_RACK;
                     end else begin
                        sda_oe <= ~tx_byte[3'd7 - bit_cnt[2:0]];
                     end
                  end
               end
               ST_RACK: begin
                  if (scl_rise) begin
                     host_nack <= sda_lvl;
                  end else if (scl_fall) begin
                     if (host_nack) begin
                        state <= ST_IGNORE;
                     end else begin
                        tx_byte <= rd_data;
                        sda_oe  <= ~rd_data[DATA_W-1];
                        bit_cnt <= '0;
                        state   <= ST_RDATA;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

endmodule

// File: rtl/i2c_regport.sv
module i2c_regport
   import i2c_regport_pkg::*;
#(
   parameter int ADDR_SEL    = 0,
   parameter int SYNC_STAGES = 2,
   parameter int PIN_W       = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             scl_i,
   input  logic             sda_i,
   output logic             sda_oe_o,
   input  logic [PIN_W-1:0] pins_i,
   output logic [7:0]       rate_a_o,
   output logic [7:0]       duty_a_o,
   output logic [7:0]       rate_b_o,
   output logic [7:0]       duty_b_o,
   output logic [7:0]       led_sel_o
);

   if (ADDR_SEL < 0 || ADDR_SEL > 1) begin : g_bad_addr
      $error("i2c_regport: ADDR_SEL must be 0 or 1");
   end
   if (PIN_W < 1 || PIN_W > DATA_W) begin : g_bad_pins
      $error("i2c_regport: PIN_W must be 1..8");
   end

   localparam logic [6:0] SLAVE_ADDR = {6'b110001, ADDR_SEL[0]};

   logic              scl_lvl, sda_lvl, scl_rise, scl_fall;
   logic              start_det, stop_det;
   logic [DATA_W-1:0] rd_data, wr_data;
   logic [PTR_W-1:0]  idx, wr_idx;
   logic              step_en, cmd_load, wr_en;

   i2c_line_sampler #(.STAGES(SYNC_STAGES)) u_samp (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_i),
      .sda_i     (sda_i),
      .scl_lvl   (scl_lvl),
      .sda_lvl   (sda_lvl),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   i2c_slave_engine #(.SLAVE_ADDR(SLAVE_ADDR)) u_eng (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .sda_lvl   (sda_lvl),
      .start_det (start_det),
      .stop_det  (stop_det),
      .rd_data   (rd_data),
      .sda_oe    (sda_oe_o),
      .idx       (idx),
      .step_en   (step_en),
      .cmd_load  (cmd_load),
      .wr_en     (wr_en),
      .wr_idx    (wr_idx),
      .wr_data   (wr_data)
   );

   regport_bank #(.PIN_W(PIN_W)) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_idx    (wr_idx),
      .wr_data   (wr_data),
      .rd_idx    (idx),
      .pins_i    (pins_i),
      .rd_data   (rd_data),
      .rate_a_o  (rate_a_o),
      .duty_a_o  (duty_a_o),
      .rate_b_o  (rate_b_o),
      .duty_b_o  (duty_b_o),
      .led_sel_o (led_sel_o)
   );

endmodule

// File: rtl/i2c_regport_chk.sv
module i2c_regport_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       scl_lvl,
   input logic       start_det,
   input logic       stop_det,
   input logic       sda_oe,
   input logic [2:0] idx,
   input logic       step_en,
   input logic       cmd_load
);

   // R8: drive changes only while sampled SCL is low
   assert_oe_scl_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe) |-> !scl_lvl);

   // R7: STOP releases the data line
   assert_stop_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> !sda_oe);

   // R7: START releases the data line
   assert_start_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
      start_det |=> !sda_oe);

   // R5: stepping from the last index lands on zero
   assert_idx_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(idx) == 3'd5 && idx != 3'd5 && !cmd_load) |-> idx == 3'd0);

   // R5: index moves outside a command load only when stepping is enabled
   assert_idx_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (idx != $past(idx) && !cmd_load) |-> $past(step_en));

endmodule

bind i2c_regport i2c_regport_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .scl_lvl   (scl_lvl),
   .start_det (start_det),
   .stop_det  (stop_det),
   .sda_oe    (sda_oe_o),
   .idx       (idx),
   .step_en   (step_en),
   .cmd_load  (cmd_load)
);

// File: tb/sim_i2c_regport.sv
module sim_i2c_regport;

   localparam int Q = 20;
   localparam logic [7:0] ADR_W = 8'hC4;
   localparam logic [7:0] ADR_R = 8'hC5;
   localparam logic [7:0] ADR_OTHER = 8'hC6;
   localparam int NVEC = 8;
   // {index, value}
   localparam logic [15:0] VEC [NVEC] = '{
      16'h01_3C, 16'h02_A5, 16'h03_01, 16'h04_00,
      16'h05_E4, 16'h00_77, 16'h02_FF, 16'h06_55 };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_m = 1'b1, sda_m = 1'b1;
   logic [3:0] pins = 4'hA;
   logic sda_oe;
   logic [7:0] rate_a, duty_a, rate_b, duty_b, led_sel;
   logic sda_line;
   int n_chk = 0, n_fail = 0;
   logic [7:0] model [0:7];
   logic ack;
   logic [7:0] b;

   always #2.5 clk = ~clk;
   assign sda_line = sda_m & ~sda_oe;

   i2c_regport u0 (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
      .sda_oe_o(sda_oe), .pins_i(pins),
      .rate_a_o(rate_a), .duty_a_o(duty_a), .rate_b_o(rate_b),
      .duty_b_o(duty_b), .led_sel_o(led_sel));

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wq();
      repeat (Q) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
   endtask

   task automatic put_byte(input logic [7:0] v, output logic a);
      for (int i = 7; i >= 0; i--) begin
         sda_m = v[i]; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
      end
      sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); a = ~sda_line; wq(); scl_m = 1'b0; wq();
   endtask

   task automatic get_byte(input logic nack, output logic [7:0] v);
      sda_m = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         wq(); scl_m = 1'b1; wq(); v[i] = sda_line; wq(); scl_m = 1'b0;
      end
      wq(); sda_m = nack; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq(); sda_m = 1'b1;
   endtask

   function automatic logic [7:0] rd_exp(input int p);
      return (p == 0) ? {4'h0, pins} : model[p];
   endfunction

   task automatic check_outputs(input string req);
      check({req, " rate_a"}, rate_a, model[1]);
      check({req, " duty_a"}, duty_a, model[2]);
      check({req, " rate_b"}, rate_b, model[3]);
      check({req, " duty_b"}, duty_b, model[4]);
      check({req, " led_sel"}, led_sel, model[5]);
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL R9 watchdog: actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      for (int i = 0; i < 8; i++) model[i] = (i == 2 || i == 4) ? 8'h80 : 8'h00;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);

      // R4 reset values, SDA released
      check_outputs("R4 reset");
      check("R7 idle release", {7'd0, sda_oe}, 8'h00);

      // R3: index resets to 0, bare read returns pins; R2 read direction
      bus_start(); put_byte(ADR_R, ack);
      check("R2 read addr ack", {7'd0, ack}, 8'h01);
      get_byte(1'b1, b); bus_stop();
      check("R3 reset index read", b, 8'h0A);

      // Table: write one register, read it back through repeated start
      for (int v = 0; v < NVEC; v++) begin
         automatic int p = int'(VEC[v][15:8]);
         automatic logic [7:0] d = VEC[v][7:0];
         bus_start(); put_byte(ADR_W, ack);
         check("R1 addr ack", {7'd0, ack}, 8'h01);
         put_byte({5'd0, p[2:0]}, ack);
         check("R3 cmd ack", {7'd0, ack}, 8'h01);
         put_byte(d, ack);
         check("R6 data ack", {7'd0, ack}, 8'h01);
         bus_stop();
         if (p >= 1 && p <= 5) model[p] = d;
         check_outputs("R4 table write");
         bus_start(); put_byte(ADR_W, ack); put_byte({5'd0, p[2:0]}, ack);
         bus_start(); put_byte(ADR_R, ack);
         get_byte(1'b1, b); bus_stop();
         check("R9 R4 table readback", b, rd_exp(p));
      end

      // R5 R6: stepped write from index 4 wraps through 5, 0, 1
      bus_start(); put_byte(ADR_W, ack); put_byte(8'h14, ack);
      put_byte(8'h11, ack); put_byte(8'h22, ack);
      put_byte(8'h33, ack);
      check("R6 pins write ack", {7'd0, ack}, 8'h01);
      put_byte(8'h44, ack); bus_stop();
      model[4] = 8'h11; model[5] = 8'h22; model[1] = 8'h44;
      check_outputs("R5 stepped write wrap");

      // R5 R9: stepped read from 5 wraps to 0 then 1
      bus_start(); put_byte(ADR_W, ack); put_byte(8'h15, ack);
      bus_start(); put_byte(ADR_R, ack);
      get_byte(1'b0, b); check("R5 burst read idx5", b, model[5]);
      get_byte(1'b0, b); check("R5 burst read wrap idx0", b, rd_exp(0));
      get_byte(1'b1, b); check("R9 burst read idx1", b, model[1]);
      bus_stop();

      // R5: without step flag the index holds
      bus_start(); put_byte(ADR_W, ack); put_byte(8'h02, ack);
      bus_start(); put_byte(ADR_R, ack);
      get_byte(1'b0, b); check("R5 hold first", b, model[2]);
      get_byte(1'b1, b); check("R5 hold second", b, model[2]);
      bus_stop();

      // R9: index persists across transfers
      bus_start(); put_byte(ADR_W, ack); put_byte(8'h03, ack); bus_stop();
      bus_start(); put_byte(ADR_R, ack); get_byte(1'b1, b); bus_stop();
      check("R9 index persists", b, model[3]);

      // R1: other address is ignored
      bus_start(); put_byte(ADR_OTHER, ack);
      check("R1 foreign addr nack", {7'd0, ack}, 8'h00);
      put_byte(8'h01, ack);
      check("R1 ignored byte nack", {7'd0, ack}, 8'h00);
      put_byte(8'h99, ack);
      // R7: a START recovers from the ignore state
      bus_start(); put_byte(ADR_W, ack);
      check("R7 restart after ignore", {7'd0, ack}, 8'h01);
      bus_stop();
      check_outputs("R1 foreign unchanged");
      check("R7 stop release", {7'd0, sda_oe}, 8'h00);

      // R4: index 0 follows the pins
      pins = 4'h5;
      bus_start(); put_byte(ADR_W, ack); put_byte(8'h00, ack);
      bus_start(); put_byte(ADR_R, ack); get_byte(1'b1, b); bus_stop();
      check("R4 pins read", b, 8'h05);

      finish_run();
   end

endmodule